// File: doc/BRIEF.md
# Supply Trim Charge-Pulse Controller

This block keeps converter outputs near a chosen voltage with a bang-bang loop. Each channel stores its most recent digitized supply sample. Once per fixed period it compares that sample with a target code and requests one charge pulse of fixed width. The pulse sources current when the supply must rise and sinks current when it must fall. If the sample lies inside a symmetric deadband around the target, no pulse is issued. The charge pump, the buffer and the hold capacitor sit outside the block. The block only produces the pulse commands, a ten-times-strength qualifier, a request to float the trim pin, and status.

A channel regulates only while its enable is set and the external sequence-done input is high. Otherwise its trim pin is floated. The per-channel target is chosen among a nominal, a high and a low code. A fast qualifier accompanies the pulses until the channel's first in-band evaluation after it became active. The ready flag reports that every enabled channel is at its set point.

Each channel is driven by a four-state machine:
- **OFF** (pin floated) goes to **IDLE** one cycle after the channel becomes active.
- **IDLE** goes to **SOURCE** or to **SINK** at a period boundary, when a sample is held and it lies below or above the band. It stays in **IDLE** when the sample is in the band.
- **SOURCE** and **SINK** return to **IDLE** when the pulse window ends.
- Every state goes to **OFF** whenever the channel becomes inactive.

One shared divider and period counter produce the period boundary and the end of the pulse window.

Top module: `trim_pulse_ctrl`

## Requirements
- R1: The period is PERIOD_CYC = DIV*PERIOD_TICKS clocks. Every pulse begins in the cycle after a period boundary and lasts exactly PULSE_CYC = DIV*PULSE_TICKS clocks. A channel issues at most one pulse per period.
- R2: Let T be the target and D the deadband. A sample below T-D gives a source pulse. A sample above T+D gives a sink pulse. A sample from T-D to T+D inclusive gives no pulse.
- R3: A channel never asserts its source and sink strobes in the same cycle.
- R4: One clock after a channel becomes inactive (enable low or sequence-done low), trim_hiz is high, no pulse is issued and at_target is low. This includes the state after reset.
- R5: While sequence-done is low, no channel issues a pulse, even when valid samples arrive.
- R6: fast_pulse is high during a pulse only while fast mode is on and the channel has had no in-band evaluation since it last became active. It stays low for later pulses.
- R7: tgt_sel selects the target: code 0 nominal, 1 high, 2 low, 3 nominal.
- R8: at_target is set by an in-band evaluation and cleared by an out-of-band one. It holds its value between evaluations.
- R9: ready is high exactly when sequence-done is high and every enabled channel has at_target high. Disabled channels are ignored.
- R10: A sample is captured when its valid strobe is high, and the latest captured sample is the one evaluated. Until the first capture after reset, no pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_done | input | 1 | External sequencing finished; regulation allowed |
| ch_en | input | NUM_CH | Per-channel regulation enable |
| fast_en | input | NUM_CH | Per-channel fast-slew mode |
| smp_valid | input | NUM_CH | Per-channel sample strobe |
| smp_data | input | NUM_CH*W | Per-channel supply samples, channel 0 in the low bits |
| tgt_sel | input | 2*NUM_CH | Per-channel target select (0 nominal, 1 high, 2 low, 3 nominal) |
| tgt_nom | input | NUM_CH*W | Per-channel nominal target codes |
| tgt_high | input | NUM_CH*W | Per-channel high target codes |
| tgt_low | input | NUM_CH*W | Per-channel low target codes |
| deadband | input | W | Half-width of the at-target band, shared by all channels |
| src_pulse | output | NUM_CH | Source-current pulse command |
| snk_pulse | output | NUM_CH | Sink-current pulse command |
| fast_pulse | output | NUM_CH | Current pulse runs at ten-times strength |
| trim_hiz | output | NUM_CH | Float the trim pin |
| at_target | output | NUM_CH | Last evaluation was inside the band |
| ready | output | 1 | All enabled channels at set point |

## Verification
The loop is tried with samples far below and far above the target, which separates the source and sink directions. Samples exactly on the band edges and one code beyond them show whether the band is inclusive. The same sample is also held while the target select moves between high, low and the spare code, which shows that the comparison follows the selected target and not a fixed one. Other runs apply samples with sequencing incomplete, run with no sample at all, disable one channel while the other stays in band, and re-enable a channel in fast mode. These separate gating from comparison and show that the fast qualifier is dropped after the first in-band evaluation.

// File: rtl/trim_pkg.sv
package trim_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_SRC  = 2'd2,
        ST_SNK  = 2'd3
    } trim_st_e;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DN   = 2'd2
    } dir_e;

    localparam logic [1:0] SEL_NOM  = 2'd0;
    localparam logic [1:0] SEL_HIGH = 2'd1;
    localparam logic [1:0] SEL_LOW  = 2'd2;
endpackage

// File: rtl/trim_timer.sv
// Shared period timer: prescaler of DIV clocks, then a tick counter (R1).
module trim_timer #(
    parameter int unsigned DIV          = 625,
    parameter int unsigned PERIOD_TICKS = 340,
    parameter int unsigned PULSE_TICKS  = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic prd_start,
    output logic pulse_end
);
    localparam int unsigned TW = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;

    logic          div_wrap;
    logic          div_zero;
    logic [TW-1:0] tick_q;

    generate
        if (DIV > 1) begin : g_div
            localparam int unsigned DW = $clog2(DIV);
            logic [DW-1:0] div_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    div_q <= '0;
                else if (div_q == DW'(DIV - 1))
                    div_q <= '0;
                else
                    div_q <= div_q + 1'b1;
            end
            assign div_wrap = (div_q == DW'(DIV - 1));
            assign div_zero = (div_q == '0);
        end else begin : g_nodiv
            assign div_wrap = 1'b1;
            assign div_zero = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tick_q <= '0;
        else if (div_wrap) begin
            if (tick_q == TW'(PERIOD_TICKS - 1))
                tick_q <= '0;
            else
                tick_q <= tick_q + 1'b1;
        end
    end

    assign prd_start = div_zero && (tick_q == '0);
    assign pulse_end = div_zero && (tick_q == TW'(PULSE_TICKS));
endmodule

// File: rtl/trim_cmp.sv
// Target selection (R7) and inclusive deadband comparison (R2).
module trim_cmp
    import trim_pkg::*;
#(
    parameter int unsigned W = 10
) (
    input  logic [W-1:0] smp,
    input  logic [W-1:0] nom,
    input  logic [W-1:0] high,
    input  logic [W-1:0] low,
    input  logic [1:0]   sel,
    input  logic [W-1:0] db,
    output dir_e         dir
);
    logic [W-1:0] tgt;
    logic [W:0]   smp_hi;
    logic [W:0]   tgt_hi;

    always_comb begin
        case (sel)
            SEL_HIGH: tgt = high;
            SEL_LOW:  tgt = low;
            default:  tgt = nom;
        endcase
    end

    assign smp_hi = {1'b0, smp} + {1'b0, db};
    assign tgt_hi = {1'b0, tgt} + {1'b0, db};

    always_comb begin
        if (smp_hi < {1'b0, tgt})
            dir = DIR_UP;
        else if ({1'b0, smp} > tgt_hi)
            dir = DIR_DN;
        else
            dir = DIR_NONE;
    end
endmodule

// File: rtl/trim_chan.sv
// One regulated channel: sample hold, state machine, status flags.
module trim_chan
    import trim_pkg::*;
#(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic         prd_start,
    input  logic         pulse_end,
    input  logic         fast_en,
    input  logic         smp_valid,
    input  logic [W-1:0] smp_data,
    input  logic [W-1:0] tgt_nom,
    input  logic [W-1:0] tgt_high,
    input  logic [W-1:0] tgt_low,
    input  logic [1:0]   tgt_sel,
    input  logic [W-1:0] deadband,
    output logic         src_pulse,
    output logic         snk_pulse,
    output logic         fast_pulse,
    output logic         trim_hiz,
    output logic         at_target
);
    trim_st_e     st_q, st_d;
    dir_e         dir;
    logic [W-1:0] smp_q;
    logic         have_q;
    logic         atg_q;
    logic         rch_q;
    logic         eval;

    trim_cmp #(.W(W)) u_cmp (
        .smp  (smp_q),
        .nom  (tgt_nom),
        .high (tgt_high),
        .low  (tgt_low),
        .sel  (tgt_sel),
        .db   (deadband),
        .dir  (dir)
    );

    // One evaluation per period, only with a captured sample (R1, R10)
    assign eval = active && (st_q == ST_IDLE) && prd_start && have_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_OFF;
        else
            st_q <= st_d;
    end

    // Transitions (R4, R5: inactive forces OFF)
    always_comb begin
        st_d = st_q;
        if (!active) begin
            st_d = ST_OFF;
        end else begin
            unique case (st_q)
                ST_OFF:  st_d = ST_IDLE;
                ST_IDLE: begin
                    if (eval) begin
                        case (dir)
                            DIR_UP:  st_d = ST_SRC;
                            DIR_DN:  st_d = ST_SNK;
                            default: st_d = ST_IDLE;
                        endcase
                    end
                end
                ST_SRC, ST_SNK: begin
                    if (pulse_end)
                        st_d = ST_IDLE;
                end
            endcase
        end
    end

    // Sample hold (R10) and status flags (R6, R8)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q  <= '0;
            have_q <= 1'b0;
            atg_q  <= 1'b0;
            rch_q  <= 1'b0;
        end else begin
            if (smp_valid) begin
                smp_q  <= smp_data;
                have_q <= 1'b1;
            end
            if (!active) begin
                atg_q <= 1'b0;
                rch_q <= 1'b0;
            end else if (eval) begin
                atg_q <= (dir == DIR_NONE);
                if (dir == DIR_NONE)
                    rch_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        src_pulse = 1'b0;
        snk_pulse = 1'b0;
        trim_hiz  = 1'b0;
        unique case (st_q)
            ST_OFF:  trim_hiz  = 1'b1;
            ST_IDLE: ;
            ST_SRC:  src_pulse = 1'b1;
            ST_SNK:  snk_pulse = 1'b1;
        endcase
        fast_pulse = (src_pulse || snk_pulse) && fast_en && !rch_q;
        at_target  = atg_q;
    end
endmodule

// File: rtl/trim_pulse_ctrl.sv
module trim_pulse_ctrl #(
    parameter int unsigned NUM_CH       = 2,
    parameter int unsigned W            = 10,
    parameter int unsigned DIV          = 625,
    parameter int unsigned PERIOD_TICKS = 340,
    parameter int unsigned PULSE_TICKS  = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  seq_done,
    input  logic [NUM_CH-1:0]     ch_en,
    input  logic [NUM_CH-1:0]     fast_en,
    input  logic [NUM_CH-1:0]     smp_valid,
    input  logic [NUM_CH*W-1:0]   smp_data,
    input  logic [2*NUM_CH-1:0]   tgt_sel,
    input  logic [NUM_CH*W-1:0]   tgt_nom,
    input  logic [NUM_CH*W-1:0]   tgt_high,
    input  logic [NUM_CH*W-1:0]   tgt_low,
    input  logic [W-1:0]          deadband,
    output logic [NUM_CH-1:0]     src_pulse,
    output logic [NUM_CH-1:0]     snk_pulse,
    output logic [NUM_CH-1:0]     fast_pulse,
    output logic [NUM_CH-1:0]     trim_hiz,
    output logic [NUM_CH-1:0]     at_target,
    output logic                  ready
);
    localparam int unsigned PULSE_CYC  = DIV * PULSE_TICKS;
    localparam int unsigned PERIOD_CYC = DIV * PERIOD_TICKS;

    logic prd_start;
    logic pulse_end;

    trim_timer #(
        .DIV          (DIV),
        .PERIOD_TICKS (PERIOD_TICKS),
        .PULSE_TICKS  (PULSE_TICKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .prd_start (prd_start),
        .pulse_end (pulse_end)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            trim_chan #(.W(W)) u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .active     (seq_done && ch_en[c]),
                .prd_start  (prd_start),
                .pulse_end  (pulse_end),
                .fast_en    (fast_en[c]),
                .smp_valid  (smp_valid[c]),
                .smp_data   (smp_data[c*W +: W]),
                .tgt_nom    (tgt_nom[c*W +: W]),
                .tgt_high   (tgt_high[c*W +: W]),
                .tgt_low    (tgt_low[c*W +: W]),
                .tgt_sel    (tgt_sel[2*c +: 2]),
                .deadband   (deadband),
                .src_pulse  (src_pulse[c]),
                .snk_pulse  (snk_pulse[c]),
                .fast_pulse (fast_pulse[c]),
                .trim_hiz   (trim_hiz[c]),
                .at_target  (at_target[c])
            );
        end
    endgenerate

    // Ready over enabled channels (R9)
    always_comb begin
        ready = seq_done;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_en[c] && !at_target[c])
                ready = 1'b0;
        end
    end

    initial begin
        if (PULSE_TICKS >= PERIOD_TICKS || PULSE_TICKS == 0 || PERIOD_CYC < 2)
            $display("trim_pulse_ctrl: pulse must be shorter than the period");
    end
endmodule

// File: rtl/trim_pulse_ctrl_chk.sv
module trim_pulse_ctrl_chk #(
    parameter int unsigned NUM_CH    = 2,
    parameter int unsigned PULSE_CYC = 625
) (
    input logic              clk,
    input logic              rst_n,
    input logic              seq_done,
    input logic [NUM_CH-1:0] ch_en,
    input logic [NUM_CH-1:0] src_pulse,
    input logic [NUM_CH-1:0] snk_pulse,
    input logic [NUM_CH-1:0] fast_pulse,
    input logic [NUM_CH-1:0] trim_hiz,
    input logic [NUM_CH-1:0] at_target,
    input logic              ready
);
    localparam int unsigned LW = $clog2(PULSE_CYC + 2) + 1;

    p_ready_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> seq_done);

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_c
            logic [LW-1:0] run_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    run_q <= '0;
                else if (src_pulse[c] || snk_pulse[c]) begin
                    if (run_q <= LW'(PULSE_CYC))
                        run_q <= run_q + 1'b1;
                end else
                    run_q <= '0;
            end

            p_pulse_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (src_pulse[c] || snk_pulse[c]) |-> (run_q < LW'(PULSE_CYC)));

            p_no_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
                src_pulse[c] |=> !snk_pulse[c]);

            p_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
                !(src_pulse[c] && snk_pulse[c]));

            p_float_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
                trim_hiz[c] |-> (!src_pulse[c] && !snk_pulse[c] && !at_target[c]));

            p_inactive_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
                !(seq_done && ch_en[c]) |=> trim_hiz[c]);

            p_fast_in_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
                fast_pulse[c] |-> (src_pulse[c] || snk_pulse[c]));

            p_ready_cover_r9: assert property (@(posedge clk) disable iff (!rst_n)
                ready |-> (!ch_en[c] || at_target[c]));
        end
    endgenerate
endmodule

bind trim_pulse_ctrl trim_pulse_ctrl_chk #(
    .NUM_CH    (NUM_CH),
    .PULSE_CYC (DIV * PULSE_TICKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .seq_done   (seq_done),
    .ch_en      (ch_en),
    .src_pulse  (src_pulse),
    .snk_pulse  (snk_pulse),
    .fast_pulse (fast_pulse),
    .trim_hiz   (trim_hiz),
    .at_target  (at_target),
    .ready      (ready)
);

// File: tb/trim_pulse_ctrl_bench.sv
`timescale 1ns/1ps
module trim_pulse_ctrl_bench;
    localparam int NC = 2;
    localparam int W  = 10;
    localparam int PC = 16;   // DIV 2 * PERIOD_TICKS 8
    localparam int PL = 4;    // DIV 2 * PULSE_TICKS 2

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            seq_done = 1'b0;
    logic [NC-1:0]   ch_en = '0;
    logic [NC-1:0]   fast_en = '0;
    logic [NC-1:0]   smp_valid = '0;
    logic [NC*W-1:0] smp_data = '0;
    logic [2*NC-1:0] tgt_sel = '0;
    logic [NC*W-1:0] tgt_nom  = {10'd500, 10'd500};
    logic [NC*W-1:0] tgt_high = {10'd600, 10'd600};
    logic [NC*W-1:0] tgt_low  = {10'd400, 10'd400};
    logic [W-1:0]    deadband = 10'd8;
    logic [NC-1:0]   src_pulse, snk_pulse, fast_pulse, trim_hiz, at_target;
    logic            ready;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    trim_pulse_ctrl #(
        .NUM_CH(NC), .W(W), .DIV(2), .PERIOD_TICKS(8), .PULSE_TICKS(2)
    ) u_trim_pulse_ctrl (
        .clk(clk), .rst_n(rst_n), .seq_done(seq_done), .ch_en(ch_en),
        .fast_en(fast_en), .smp_valid(smp_valid), .smp_data(smp_data),
        .tgt_sel(tgt_sel), .tgt_nom(tgt_nom), .tgt_high(tgt_high),
        .tgt_low(tgt_low), .deadband(deadband), .src_pulse(src_pulse),
        .snk_pulse(snk_pulse), .fast_pulse(fast_pulse), .trim_hiz(trim_hiz),
        .at_target(at_target), .ready(ready)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: 0 off, 1 idle, 2 source, 3 sink
    int m_cyc;
    int m_st[NC];
    int m_smp[NC];
    bit m_have[NC], m_atg[NC], m_rch[NC];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cyc = 0;
            for (int c = 0; c < NC; c++) begin
                m_st[c] = 0; m_smp[c] = 0; m_have[c] = 0; m_atg[c] = 0; m_rch[c] = 0;
            end
        end else begin
            for (int c = 0; c < NC; c++) begin
                int t;
                int s;
                s = tgt_sel[2*c +: 2];
                t = (s == 1) ? int'(tgt_high[c*W +: W]) :
                    (s == 2) ? int'(tgt_low[c*W +: W]) : int'(tgt_nom[c*W +: W]);
                if (!(seq_done && ch_en[c])) begin
                    m_st[c] = 0; m_atg[c] = 0; m_rch[c] = 0;
                end else if (m_st[c] == 0) begin
                    m_st[c] = 1;
                end else if (m_st[c] == 1) begin
                    if (m_cyc == 0 && m_have[c]) begin
                        if (m_smp[c] < t - int'(deadband)) begin
                            m_st[c] = 2; m_atg[c] = 0;
                        end else if (m_smp[c] > t + int'(deadband)) begin
                            m_st[c] = 3; m_atg[c] = 0;
                        end else begin
                            m_atg[c] = 1; m_rch[c] = 1;
                        end
                    end
                end else if (m_cyc == PL) begin
                    m_st[c] = 1;
                end
                if (smp_valid[c]) begin
                    m_smp[c] = int'(smp_data[c*W +: W]);
                    m_have[c] = 1;
                end
            end
            m_cyc = (m_cyc + 1) % PC;
        end
    end

    // Per-clock comparison and scenario counters
    int run[NC];
    int src_cnt[NC], snk_cnt[NC], fast_cnt[NC];

    always @(posedge clk) begin
        #2;
        if (!done) begin
            bit all_ok;
            all_ok = seq_done;
            for (int c = 0; c < NC; c++) begin
                bool_chk(c);
                if (ch_en[c] && !m_atg[c]) all_ok = 0;
            end
            check(ready == all_ok, "R9 ready", ready, all_ok);
        end
    end

    task automatic bool_chk(input int c);
        bit es, ek, ef;
        es = (m_st[c] == 2);
        ek = (m_st[c] == 3);
        ef = (es || ek) && fast_en[c] && !m_rch[c];
        check(src_pulse[c] == es, $sformatf("R2 source ch%0d", c), src_pulse[c], es);
        check(snk_pulse[c] == ek, $sformatf("R2 sink ch%0d", c), snk_pulse[c], ek);
        check(!(src_pulse[c] && snk_pulse[c]), $sformatf("R3 exclusive ch%0d", c), 1, 0);
        check(trim_hiz[c] == (m_st[c] == 0), $sformatf("R4 float ch%0d", c), trim_hiz[c], m_st[c] == 0);
        check(fast_pulse[c] == ef, $sformatf("R6 fast ch%0d", c), fast_pulse[c], ef);
        check(at_target[c] == m_atg[c], $sformatf("R8 at_target ch%0d", c), at_target[c], m_atg[c]);
        if (src_pulse[c] || snk_pulse[c]) begin
            if (run[c] == 0)
                check(m_cyc == 1, $sformatf("R1 pulse start ch%0d", c), m_cyc, 1);
            run[c]++;
            if (src_pulse[c]) src_cnt[c]++;
            if (snk_pulse[c]) snk_cnt[c]++;
            if (fast_pulse[c]) fast_cnt[c]++;
        end else begin
            if (run[c] > 0)
                check(run[c] == PL, $sformatf("R1 pulse length ch%0d", c), run[c], PL);
            run[c] = 0;
        end
    endtask

    task automatic clr();
        for (int c = 0; c < NC; c++) begin
            src_cnt[c] = 0; snk_cnt[c] = 0; fast_cnt[c] = 0;
        end
    endtask

    task automatic periods(input int n);
        repeat (n * PC) @(negedge clk);
    endtask

    task automatic put(input int c, input int v);
        @(negedge clk);
        smp_data[c*W +: W] = W'(v);
        smp_valid[c] = 1'b1;
        @(negedge clk);
        smp_valid[c] = 1'b0;
    endtask

    task automatic settle_and_count();
        periods(1);
        clr();
        periods(2);
    endtask

    initial begin
        for (int c = 0; c < NC; c++) run[c] = 0;
        clr();
        repeat (3) @(negedge clk);
        check(trim_hiz == 2'b11, "R4 reset float", trim_hiz, 3);
        check(src_pulse == 0 && snk_pulse == 0, "R4 reset quiet", src_pulse | snk_pulse, 0);
        rst_n = 1'b1;

        // R10: active but no sample yet captured
        seq_done = 1; ch_en = 2'b11;
        clr(); periods(3);
        for (int c = 0; c < NC; c++)
            check(src_cnt[c] + snk_cnt[c] == 0, "R10 no sample no pulse", src_cnt[c] + snk_cnt[c], 0);

        // R5: samples while sequencing incomplete
        seq_done = 0;
        put(0, 300); put(1, 300);
        clr(); periods(3);
        for (int c = 0; c < NC; c++)
            check(src_cnt[c] + snk_cnt[c] == 0, "R5 gated by seq_done", src_cnt[c] + snk_cnt[c], 0);
        check(trim_hiz == 2'b11, "R4 float while gated", trim_hiz, 3);

        // R2: below and above
        seq_done = 1;
        put(0, 300); put(1, 700);
        settle_and_count();
        check(src_cnt[0] > 0 && snk_cnt[0] == 0, "R2 low sample sources", src_cnt[0], PL);
        check(snk_cnt[1] > 0 && src_cnt[1] == 0, "R2 high sample sinks", snk_cnt[1], PL);

        // R7: select high / low, then spare code
        tgt_sel = 4'b1001;
        put(0, 550); put(1, 550);
        settle_and_count();
        check(src_cnt[0] > 0 && snk_cnt[0] == 0, "R7 high target", src_cnt[0], PL);
        check(snk_cnt[1] > 0 && src_cnt[1] == 0, "R7 low target", snk_cnt[1], PL);
        tgt_sel = 4'b1111;
        settle_and_count();
        check(snk_cnt[0] > 0 && snk_cnt[1] > 0, "R7 code 3 nominal", snk_cnt[0] + snk_cnt[1], 2 * PL);

        // R2 band edges
        tgt_sel = 4'b0000;
        put(0, 508); put(1, 492);
        settle_and_count();
        check(src_cnt[0] + snk_cnt[0] + src_cnt[1] + snk_cnt[1] == 0, "R2 edge inside band", src_cnt[0] + snk_cnt[1], 0);
        check(at_target == 2'b11 && ready, "R8 at target on edge", at_target, 3);
        put(0, 509); put(1, 491);
        settle_and_count();
        check(snk_cnt[0] > 0 && src_cnt[1] > 0, "R2 one beyond band", snk_cnt[0] + src_cnt[1], 2 * PL);

        // R9: disable channel 1 while channel 0 in band
        put(0, 505); put(1, 505);
        periods(2);
        ch_en = 2'b01;
        put(1, 0);
        settle_and_count();
        check(trim_hiz[1] && src_cnt[1] + snk_cnt[1] == 0, "R4 disabled channel quiet", trim_hiz[1], 1);
        check(ready == 1'b1, "R9 disabled channel ignored", ready, 1);

        // R6: fast until first in-band evaluation
        fast_en = 2'b10;
        put(1, 300);
        ch_en = 2'b11;
        clr(); periods(2);
        check(fast_cnt[1] > 0, "R6 fast before target", fast_cnt[1], PL);
        put(1, 500);
        periods(2);
        put(1, 300);
        settle_and_count();
        check(src_cnt[1] > 0 && fast_cnt[1] == 0, "R6 normal after target", fast_cnt[1], 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        checks++;
        errors++;
        done = 1;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule